// File: doc/BRIEF.md
# Mailbox RPC Doorbell Controller

This block is a shared word memory that an external host and an on-chip soft processor use to carry remote procedure calls. The host fills word 1 onward with parameter words and places a command word at word 0. It then raises a message-available line. The processor side sees a request-pending flag, together with the instance, channel and procedure fields decoded from word 0. It services the call and writes return words from word 1 onward. It signals completion by writing zero over word 0. The host learns that the call is done by polling word 0 until it reads zero.

Each side has a plain synchronous port that accepts an access on every cycle. There is no back-pressure: an enabled access is always taken on the next rising clock edge. A read returns its word in the cycle after the request, and the read data holds between reads. Every word is 32 bits wide. Data items are packed little-endian and left-aligned within their words. A variable-length item is sent as a byte-count word followed by its data words. Instance 0 is kept for the subsystem's own discovery and auxiliary calls, and the block flags that case. The depth is a parameter and must be a power of two; the default is 256 words.

Top module: `mbox_rpc_ctrl`

## Requirements
- R1: After reset, word 0 is zero, both read-data outputs are zero, `req_pending` is 0 and `call_done` is 0.
- R2: An enabled write on either port stores the word at the next clock edge. An enabled read with the write-enable low returns the addressed word one cycle later, as it was before any write on that same edge. The read data holds its value when no read is made.
- R3: If both ports write the same word on the same edge, the processor-side data is stored. This applies to word 0 as well.
- R4: `cmd_inst` is word 0 bits 31:24, `cmd_chan` is bits 23:12 and `cmd_proc` is bits 11:0, and all three follow word 0 as it is currently stored.
- R5: A rising edge of `msg_avail` at a clock edge makes `req_pending` 1 from the next cycle. Keeping `msg_avail` high does not set the flag again.
- R6: Writing the value zero to word 0 from either port clears `req_pending` from the next cycle.
- R7: If a rising edge of `msg_avail` and a zero write to word 0 occur on the same edge, `req_pending` ends up 1.
- R8: `call_done` is high for exactly one cycle, the cycle after an edge where word 0 goes from nonzero to zero while `req_pending` is 1. A zero write to a word 0 that is already zero, or a zero write made while nothing is pending, gives no pulse.
- R9: `sys_call` is 1 exactly when `req_pending` is 1 and `cmd_inst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word, one cycle after the request |
| msg_avail | input | 1 | Host doorbell; its rising edge posts a call |
| cpu_en | input | 1 | Processor access enable |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Processor read word, one cycle after the request |
| req_pending | output | 1 | A posted call awaits completion |
| cmd_inst | output | 8 | Instance field of word 0 |
| cmd_chan | output | 12 | Channel field of word 0 |
| cmd_proc | output | 12 | Procedure field of word 0 |
| sys_call | output | 1 | Pending call addresses instance 0 |
| call_done | output | 1 | One-cycle completion pulse |

## Verification
Several functions can land on the same clock edge, and the bench provokes each case on purpose. In the first case, the doorbell's rising edge falls on the cycle where the processor zeroes word 0, so a new call arrives as the old one completes. In the second, both ports write the same word, including word 0 with a zero from the processor against a nonzero word from the host. In each case a behavioural model holds the expected pending flag, the done pulse, the decoded fields and the stored words, and it is compared with the outputs on every cycle. The model judges that the doorbell wins, that the processor's data wins, and that the pulse appears only when the stored word goes from nonzero to zero.

// File: rtl/mbox_rpc_pkg.sv
package mbox_rpc_pkg;
  localparam int WORD_W = 32;
  localparam int INST_W = 8;
  localparam int CHAN_W = 12;
  localparam int PROC_W = 12;

  typedef struct packed {
    logic [INST_W-1:0] inst;
    logic [CHAN_W-1:0] chan;
    logic [PROC_W-1:0] proc_id;
  } cmd_word_t;
endpackage

// File: rtl/mbox_rpc_store.sv
module mbox_rpc_store
  import mbox_rpc_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_en,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  input  logic              c_en,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [WORD_W-1:0] c_wdata,
  output logic [WORD_W-1:0] c_rdata,
  output logic [WORD_W-1:0] cmd_word,
  output logic              w0_wr,
  output logic [WORD_W-1:0] w0_data
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = '0;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] cmd_q;
  logic h_wr, c_wr, h_wr_arr, c_wr_arr, same_word;

  assign h_wr      = h_en && h_we;
  assign c_wr      = c_en && c_we;
  assign same_word = h_wr && c_wr && (h_addr == c_addr);
  assign h_wr_arr  = h_wr && (h_addr != CMD_ADDR) && !same_word;
  assign c_wr_arr  = c_wr && (c_addr != CMD_ADDR);

  // word 0 path: processor data takes priority on a collision
  assign w0_wr   = (h_wr && h_addr == CMD_ADDR) || (c_wr && c_addr == CMD_ADDR);
  assign w0_data = (c_wr && c_addr == CMD_ADDR) ? c_wdata : h_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (w0_wr) cmd_q <= w0_data;
  end

  always_ff @(posedge clk) begin
    if (h_wr_arr) mem[h_addr] <= h_wdata;
    if (c_wr_arr) mem[c_addr] <= c_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
      c_rdata <= '0;
    end else begin
      if (h_en && !h_we) h_rdata <= (h_addr == CMD_ADDR) ? cmd_q : mem[h_addr];
      if (c_en && !c_we) c_rdata <= (c_addr == CMD_ADDR) ? cmd_q : mem[c_addr];
    end
  end

  assign cmd_word = cmd_q;
endmodule

// File: rtl/mbox_rpc_bell.sv
module mbox_rpc_bell
  import mbox_rpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_avail,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              w0_wr,
  input  logic [WORD_W-1:0] w0_data,
  output logic              pending,
  output logic              done
);
  logic msg_q, rise, zero_wr;

  assign rise    = msg_avail && !msg_q;
  assign zero_wr = w0_wr && (w0_data == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q   <= 1'b0;
      pending <= 1'b0;
      done    <= 1'b0;
    end else begin
      msg_q <= msg_avail;
      // a new doorbell outranks a completion on the same edge
      if (rise)         pending <= 1'b1;
      else if (zero_wr) pending <= 1'b0;
      done <= pending && zero_wr && (cmd_word != '0);
    end
  end
endmodule

// File: rtl/mbox_rpc_decode.sv
module mbox_rpc_decode
  import mbox_rpc_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              pending,
  output logic [INST_W-1:0] inst,
  output logic [CHAN_W-1:0] chan,
  output logic [PROC_W-1:0] proc_id,
  output logic              sys
);
  cmd_word_t f;
  assign f       = cmd_word_t'(cmd_word);
  assign inst    = f.inst;
  assign chan    = f.chan;
  assign proc_id = f.proc_id;
  assign sys     = pending && (f.inst == '0);
endmodule

// File: rtl/mbox_rpc_ctrl.sv
module mbox_rpc_ctrl
  import mbox_rpc_pkg::*;
#(
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              msg_avail,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              req_pending,
  output logic [7:0]        cmd_inst,
  output logic [11:0]       cmd_chan,
  output logic [11:0]       cmd_proc,
  output logic              sys_call,
  output logic              call_done
);
  logic [WORD_W-1:0] cmd_word, w0_data;
  logic              w0_wr;

  mbox_rpc_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .h_en(host_en), .h_we(host_we), .h_addr(host_addr),
    .h_wdata(host_wdata), .h_rdata(host_rdata),
    .c_en(cpu_en), .c_we(cpu_we), .c_addr(cpu_addr),
    .c_wdata(cpu_wdata), .c_rdata(cpu_rdata),
    .cmd_word(cmd_word), .w0_wr(w0_wr), .w0_data(w0_data)
  );

  mbox_rpc_bell bell_i (
    .clk(clk), .rst_n(rst_n), .msg_avail(msg_avail),
    .cmd_word(cmd_word), .w0_wr(w0_wr), .w0_data(w0_data),
    .pending(req_pending), .done(call_done)
  );

  mbox_rpc_decode dec_i (
    .cmd_word(cmd_word), .pending(req_pending),
    .inst(cmd_inst), .chan(cmd_chan), .proc_id(cmd_proc), .sys(sys_call)
  );
endmodule

// File: rtl/mbox_rpc_ctrl_chk.sv
module mbox_rpc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_avail,
  input logic        req_pending,
  input logic [7:0]  cmd_inst,
  input logic [11:0] cmd_chan,
  input logic [11:0] cmd_proc,
  input logic        sys_call,
  input logic        call_done
);
  // R5
  doorbell_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_avail) |=> req_pending);
  // R5
  pend_needs_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pending) |-> $past(msg_avail));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_done |=> !call_done);
  // R8
  done_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_done |-> $past(req_pending));
  // R8
  done_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_done |-> (cmd_inst == 8'd0 && cmd_chan == 12'd0 && cmd_proc == 12'd0));
  // R9
  sys_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_call |-> req_pending);
endmodule

bind mbox_rpc_ctrl mbox_rpc_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .msg_avail(msg_avail), .req_pending(req_pending),
  .cmd_inst(cmd_inst), .cmd_chan(cmd_chan), .cmd_proc(cmd_proc),
  .sys_call(sys_call), .call_done(call_done)
);

// File: tb/mbox_rpc_ctrl_tb_top.sv
module mbox_rpc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          h_en = 0, h_we = 0, c_en = 0, c_we = 0, msg = 0;
  logic [AW-1:0] h_addr = '0, c_addr = '0;
  logic [31:0]   h_wd = '0, c_wd = '0;
  logic [31:0]   h_rd, c_rd;
  logic          pend, done, sys;
  logic [7:0]    inst;
  logic [11:0]   chan, prc;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  logic [31:0] m_mem [int];
  logic [31:0] e_hrd, e_crd;
  bit          e_hok, e_cok;
  bit          m_pend, m_done, m_msg;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_rpc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_en(h_en), .host_we(h_we), .host_addr(h_addr),
    .host_wdata(h_wd), .host_rdata(h_rd), .msg_avail(msg),
    .cpu_en(c_en), .cpu_we(c_we), .cpu_addr(c_addr),
    .cpu_wdata(c_wd), .cpu_rdata(c_rd),
    .req_pending(pend), .cmd_inst(inst), .cmd_chan(chan), .cmd_proc(prc),
    .sys_call(sys), .call_done(done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    if (e_hok) chk("R2", "host_rdata", h_rd, e_hrd);
    if (e_cok) chk("R2", "cpu_rdata", c_rd, e_crd);
    chk("R5", "req_pending", {31'd0, pend}, {31'd0, m_pend});
    chk("R8", "call_done", {31'd0, done}, {31'd0, m_done});
    chk("R4", "cmd_inst", {24'd0, inst}, {24'd0, m_mem[0][31:24]});
    chk("R4", "cmd_chan", {20'd0, chan}, {20'd0, m_mem[0][23:12]});
    chk("R4", "cmd_proc", {20'd0, prc}, {20'd0, m_mem[0][11:0]});
    chk("R9", "sys_call", {31'd0, sys}, {31'd0, m_pend && m_mem[0][31:24] == 8'd0});
  endtask

  // one clock: inputs already driven; update the model and compare after the edge
  task automatic cyc();
    bit w0, rise, zw;
    logic [31:0] w0d;
    @(posedge clk);
    #2;
    if (h_en && !h_we) begin
      e_hok = m_mem.exists(int'(h_addr));
      if (e_hok) e_hrd = m_mem[int'(h_addr)];
    end
    if (c_en && !c_we) begin
      e_cok = m_mem.exists(int'(c_addr));
      if (e_cok) e_crd = m_mem[int'(c_addr)];
    end
    w0   = (h_en && h_we && h_addr == 0) || (c_en && c_we && c_addr == 0);
    w0d  = (c_en && c_we && c_addr == 0) ? c_wd : h_wd;
    zw   = w0 && (w0d == 32'd0);
    rise = msg && !m_msg;
    m_done = m_pend && zw && (m_mem[0] != 32'd0);
    m_pend = rise ? 1'b1 : (zw ? 1'b0 : m_pend);
    m_msg  = msg;
    if (h_en && h_we) m_mem[int'(h_addr)] = h_wd;
    if (c_en && c_we) m_mem[int'(c_addr)] = c_wd;
    compare_all();
    h_en = 0; h_we = 0; c_en = 0; c_we = 0;
  endtask

  task automatic hwr(int a, logic [31:0] d);
    h_en = 1; h_we = 1; h_addr = AW'(a); h_wd = d; cyc();
  endtask
  task automatic cwr(int a, logic [31:0] d);
    c_en = 1; c_we = 1; c_addr = AW'(a); c_wd = d; cyc();
  endtask
  task automatic hrd(int a);
    h_en = 1; h_we = 0; h_addr = AW'(a); cyc();
  endtask
  task automatic crd(int a);
    c_en = 1; c_we = 0; c_addr = AW'(a); cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_mem[0] = 32'd0;
    e_hrd = 0; e_crd = 0; e_hok = 1; e_cok = 1;
    m_pend = 0; m_done = 0; m_msg = 0;
    #(CLK_PERIOD * 3 + 2);
    // R1: reset state
    chk("R1", "reset host_rdata", h_rd, 32'd0);
    chk("R1", "reset cpu_rdata", c_rd, 32'd0);
    chk("R1", "reset pending", {31'd0, pend}, 32'd0);
    chk("R1", "reset done", {31'd0, done}, 32'd0);
    chk("R1", "reset word0", {inst, chan, prc}, 32'd0);
    rst_n = 1'b1;
    cyc();

    // R2: parameters from host, read back on both ports
    hwr(1, 32'h0000_0010);
    hwr(2, 32'h6c6c_6548);
    hwr(255, 32'hdead_beef);
    crd(1); crd(2); hrd(255);
    // R2: read sees old value on a same-edge write
    h_en = 1; h_we = 0; h_addr = AW'(2); c_en = 1; c_we = 1; c_addr = AW'(2); c_wd = 32'h1234_5678; cyc();
    hrd(2);
    cyc();  // read data holds

    // R3: collision on a parameter word
    h_en = 1; h_we = 1; h_addr = AW'(5); h_wd = 32'haaaa_aaaa;
    c_en = 1; c_we = 1; c_addr = AW'(5); c_wd = 32'h5555_5555; cyc();
    hrd(5);

    // R4 R5: command word then doorbell
    hwr(0, 32'h1234_5678);
    msg = 1; cyc();
    cyc(); cyc();
    crd(0);
    // R8: return value then completion
    cwr(1, 32'h0000_0001);
    cwr(0, 32'd0);
    cyc();
    hrd(0); hrd(1);
    // R5: held doorbell does not set again
    cyc(); cyc();
    msg = 0; cyc();
    // R8: zero write with nothing pending gives no pulse
    hwr(0, 32'h0100_0001); cwr(0, 32'd0); cyc();

    // R9: instance 0 call
    hwr(0, 32'h0000_0002);
    msg = 1; cyc(); cyc();
    msg = 0; cyc();
    // R7: doorbell edge and completion on the same edge
    msg = 1; c_en = 1; c_we = 1; c_addr = '0; c_wd = 32'd0; cyc();
    cyc();
    // R6: host zero write clears pending; word already zero so no pulse (R8)
    hwr(0, 32'd0); cyc();
    msg = 0; cyc();

    // R3: collision on word 0, cpu zero wins and completes the call (R8)
    hwr(0, 32'h0a00_3003);
    msg = 1; cyc(); cyc();
    h_en = 1; h_we = 1; h_addr = '0; h_wd = 32'hffff_ffff;
    c_en = 1; c_we = 1; c_addr = '0; c_wd = 32'd0; cyc();
    cyc(); hrd(0);
    msg = 0; cyc(); cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule